// File: doc/BRIEF.md
# PCI to ISA Interrupt Router

This block maps level-sensitive interrupt requests onto a bank of sixteen ISA IRQ lines. Sources arrive one event per clock on a single event port that carries a level, a source ID and an interrupt-line number. IDs 8 to 11 are the four PCI interrupt pins, and these take their target IRQ from nibbles of three router configuration bytes. IDs 0 to 7 are on-chip functions, and each supplies its own line number with the event. The interrupt controller that consumes the IRQ lines is outside the block.

The router keeps a live vector holding the latest level of every source. For each IRQ it also keeps a bitmap of the sources that are asserting that IRQ. Each time a valid event updates a bitmap, the bitmap is masked with the live vector. This drops bits left behind when a source was re-routed and then released while it pointed somewhere else. An IRQ output is high while its bitmap is nonzero. A route to an illegal IRQ changes nothing and raises a one-cycle fault pulse that carries the offending source ID.

Top module: `irq_router`

## Requirements
- R1: After reset all IRQ outputs are 0 and fault_valid is 0.
- R2: Source 8 routes to rt_byte_a[7:4], source 9 to rt_byte_bc[3:0], source 10 to rt_byte_bc[7:4] and source 11 to rt_byte_d[7:4]. For these sources evt_line has no effect, and the other nibbles of the configuration bytes have no effect.
- R3: Sources 0 to 7 route to the IRQ number given on evt_line.
- R4: A route value of 0, or of all ones (0xFF), leaves every IRQ output unchanged and raises no fault. The source's live level is still updated.
- R5: A route to IRQ 2, or to an IRQ above the source's limit, leaves every IRQ output unchanged. The limit is 14 for sources 2, 3 and 5 and 15 for all other sources. The next cycle shows fault_valid high for exactly that event, with fault_src equal to the event's source ID.
- R6: A valid route sets or clears the source's bit in the target IRQ's bitmap. The bitmap is then ANDed with the updated live vector, so a stale bit from a source that has since dropped is removed.
- R7: An IRQ output is the OR of its bitmap, so an IRQ shared by several sources stays high until the last of them is cleared. One event changes at most one IRQ output.
- R8: An event accepted at a clock edge is visible on isa_irq and fault_valid immediately after that edge. With no event, the outputs hold.
- R9: Events with a source ID of 12 or more change no output and raise no fault.
- R10: fault_valid is high only in the cycle after an invalid route and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_level | input | 1 | New level of the source |
| evt_src | input | 4 | Source ID (0-7 functions, 8-11 PCI pins) |
| evt_line | input | 8 | Target IRQ for sources 0-7 |
| rt_byte_a | input | 8 | Config byte, upper nibble routes pin A |
| rt_byte_bc | input | 8 | Config byte, lower nibble pin B, upper nibble pin C |
| rt_byte_d | input | 8 | Config byte, upper nibble routes pin D |
| isa_irq | output | 16 | Registered ISA IRQ levels |
| fault_valid | output | 1 | One-cycle invalid-route pulse |
| fault_src | output | 4 | Source ID of the faulting event |

## Verification
The bench builds the router with its default parameters: sixteen IRQ lines, twelve sources, a 4-bit ID and an 8-bit line number. The 4-bit ID brings the unused IDs 12 to 15 within reach. The 8-bit line number reaches the all-ones disable code and values above 15. The default reduced-limit mask puts the 14 and 15 limits side by side on neighbouring sources. Routing two sources to one IRQ and then releasing one of them while it is disabled exposes the stale-bit masking.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;
  typedef enum logic [1:0] {
    RT_DROP  = 2'd0,
    RT_APPLY = 2'd1,
    RT_FAULT = 2'd2
  } route_kind_e;
endpackage

// File: rtl/irq_rtr_resolve.sv
module irq_rtr_resolve
  import irq_rtr_pkg::*;
#(
  parameter int NUM_SRC  = 12,
  parameter int SRC_W    = 4,
  parameter int LINE_W   = 8,
  parameter int PIN_BASE = 8,
  parameter logic [NUM_SRC-1:0] LOW_MAX_MASK = 12'h02C,
  parameter int LOW_MAX  = 14,
  parameter int HIGH_MAX = 15
) (
  input  logic [SRC_W-1:0]  src,
  input  logic [LINE_W-1:0] line,
  input  logic [7:0]        byte_a,
  input  logic [7:0]        byte_bc,
  input  logic [7:0]        byte_d,
  output route_kind_e       kind,
  output logic [LINE_W-1:0] target
);
  localparam logic [LINE_W-1:0] OFF_ALL = '1;
  localparam logic [LINE_W-1:0] CASCADE = LINE_W'(2);

  logic unused_cfg;
  assign unused_cfg = &{1'b0, byte_a[3:0], byte_d[3:0]};

  logic              in_range;
  logic [LINE_W-1:0] limit;

  always_comb begin
    in_range = (src < SRC_W'(NUM_SRC));
    target   = line;
    if (src == SRC_W'(PIN_BASE))          target = LINE_W'(byte_a[7:4]);
    else if (src == SRC_W'(PIN_BASE + 1)) target = LINE_W'(byte_bc[3:0]);
    else if (src == SRC_W'(PIN_BASE + 2)) target = LINE_W'(byte_bc[7:4]);
    else if (src == SRC_W'(PIN_BASE + 3)) target = LINE_W'(byte_d[7:4]);

    limit = LINE_W'(HIGH_MAX);
    if (in_range && LOW_MAX_MASK[src]) limit = LINE_W'(LOW_MAX);

    if (!in_range)                                  kind = RT_DROP;
    else if (target == '0 || target == OFF_ALL)     kind = RT_DROP;
    else if (target == CASCADE || target > limit)   kind = RT_FAULT;
    else                                            kind = RT_APPLY;
  end
endmodule

// File: rtl/irq_rtr_live.sv
module irq_rtr_live #(
  parameter int NUM_SRC = 12,
  parameter int SRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic [SRC_W-1:0]   src,
  input  logic               level,
  output logic [NUM_SRC-1:0] live_nx
);
  logic [NUM_SRC-1:0] live_q;

  always_comb begin
    live_nx = live_q;
    if (upd && src < SRC_W'(NUM_SRC)) live_nx[src] = level;
  end

  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= live_nx;
  end
endmodule

// File: rtl/irq_rtr_bank.sv
module irq_rtr_bank #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_SRC = 12,
  parameter int SRC_W   = 4,
  parameter int IRQ_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               apply,
  input  logic [IRQ_W-1:0]   irq,
  input  logic [SRC_W-1:0]   src,
  input  logic               level,
  input  logic [NUM_SRC-1:0] live_nx,
  output logic [NUM_IRQ-1:0] irq_out
);
  logic [NUM_SRC-1:0] sel;
  assign sel = NUM_SRC'(1) << src;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    logic [NUM_SRC-1:0] map_q;
    logic [NUM_SRC-1:0] map_d;
    logic               hot_q;

    always_comb begin
      map_d = map_q;
      if (apply && irq == IRQ_W'(k)) begin
        map_d = (map_q & ~sel) | (level ? sel : '0);
        map_d = map_d & live_nx;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        map_q <= '0;
        hot_q <= 1'b0;
      end else begin
        map_q <= map_d;
        hot_q <= |map_d;
      end
    end

    assign irq_out[k] = hot_q;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rtr_pkg::*;
#(
  parameter int NUM_IRQ  = 16,
  parameter int NUM_SRC  = 12,
  parameter int SRC_W    = 4,
  parameter int LINE_W   = 8,
  parameter int PIN_BASE = 8,
  parameter logic [NUM_SRC-1:0] LOW_MAX_MASK = 12'h02C,
  parameter int LOW_MAX  = 14,
  parameter int HIGH_MAX = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic               evt_level,
  input  logic [SRC_W-1:0]   evt_src,
  input  logic [LINE_W-1:0]  evt_line,
  input  logic [7:0]         rt_byte_a,
  input  logic [7:0]         rt_byte_bc,
  input  logic [7:0]         rt_byte_d,
  output logic [NUM_IRQ-1:0] isa_irq,
  output logic               fault_valid,
  output logic [SRC_W-1:0]   fault_src
);
  localparam int IRQ_W = $clog2(NUM_IRQ);

  route_kind_e        kind;
  logic [LINE_W-1:0]  target;
  logic [NUM_SRC-1:0] live_nx;
  logic               apply;
  logic               fault_d;

  irq_rtr_resolve #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .LINE_W(LINE_W), .PIN_BASE(PIN_BASE),
    .LOW_MAX_MASK(LOW_MAX_MASK), .LOW_MAX(LOW_MAX), .HIGH_MAX(HIGH_MAX)
  ) u_resolve (
    .src(evt_src), .line(evt_line), .byte_a(rt_byte_a), .byte_bc(rt_byte_bc),
    .byte_d(rt_byte_d), .kind(kind), .target(target)
  );

  irq_rtr_live #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_live (
    .clk(clk), .rst(rst), .upd(evt_valid), .src(evt_src),
    .level(evt_level), .live_nx(live_nx)
  );

  assign apply   = evt_valid && (kind == RT_APPLY);
  assign fault_d = evt_valid && (kind == RT_FAULT);

  logic unused_hi;
  assign unused_hi = &{1'b0, target[LINE_W-1:IRQ_W]};

  irq_rtr_bank #(
    .NUM_IRQ(NUM_IRQ), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .IRQ_W(IRQ_W)
  ) u_bank (
    .clk(clk), .rst(rst), .apply(apply), .irq(target[IRQ_W-1:0]),
    .src(evt_src), .level(evt_level), .live_nx(live_nx), .irq_out(isa_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid <= 1'b0;
      fault_src   <= '0;
    end else begin
      fault_valid <= fault_d;
      if (fault_d) fault_src <= evt_src;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_IRQ  = 16,
  parameter int NUM_SRC  = 12,
  parameter int SRC_W    = 4,
  parameter int LINE_W   = 8,
  parameter int PIN_BASE = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               evt_valid,
  input logic               evt_level,
  input logic [SRC_W-1:0]   evt_src,
  input logic [LINE_W-1:0]  evt_line,
  input logic [7:0]         rt_byte_a,
  input logic [7:0]         rt_byte_bc,
  input logic [7:0]         rt_byte_d,
  input logic [NUM_IRQ-1:0] isa_irq,
  input logic               fault_valid,
  input logic [SRC_W-1:0]   fault_src
);
  logic armed;
  logic unused_chk;
  assign unused_chk = &{1'b0, evt_level, rt_byte_a, rt_byte_bc, rt_byte_d};

  always_ff @(posedge clk) armed <= !rst;

  a_r10_fault_needs_event: assert property (@(posedge clk) disable iff (rst)
    armed && fault_valid |-> $past(evt_valid));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!evt_valid) |-> $stable(isa_irq) && !fault_valid);

  a_r7_one_line_moves: assert property (@(posedge clk) disable iff (rst)
    armed |-> $countones(isa_irq ^ $past(isa_irq)) <= 1);

  a_r9_foreign_src: assert property (@(posedge clk) disable iff (rst)
    armed && $past(evt_valid && evt_src >= SRC_W'(NUM_SRC))
    |-> $stable(isa_irq) && !fault_valid);

  a_r4_route_off: assert property (@(posedge clk) disable iff (rst)
    armed && $past(evt_valid && evt_src < SRC_W'(PIN_BASE) &&
                   (evt_line == LINE_W'(0) || &evt_line))
    |-> $stable(isa_irq) && !fault_valid);

  a_r5_cascade_fault: assert property (@(posedge clk) disable iff (rst)
    armed && $past(evt_valid && evt_src < SRC_W'(PIN_BASE) && evt_line == LINE_W'(2))
    |-> fault_valid && fault_src == $past(evt_src) && $stable(isa_irq));
endmodule

bind irq_router irq_router_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W),
  .LINE_W(LINE_W), .PIN_BASE(PIN_BASE)
) u_chk (.*);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic        evt_level = 1'b0;
  logic [3:0]  evt_src = '0;
  logic [7:0]  evt_line = '0;
  logic [7:0]  rt_byte_a = '0;
  logic [7:0]  rt_byte_bc = '0;
  logic [7:0]  rt_byte_d = '0;
  logic [15:0] isa_irq;
  logic        fault_valid;
  logic [3:0]  fault_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [11:0] live;
  bit [11:0] bmap [16];
  bit [15:0] exp_irq;
  bit        exp_fault;
  int        exp_fsrc;

  always #2 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_level(evt_level),
    .evt_src(evt_src), .evt_line(evt_line), .rt_byte_a(rt_byte_a),
    .rt_byte_bc(rt_byte_bc), .rt_byte_d(rt_byte_d), .isa_irq(isa_irq),
    .fault_valid(fault_valid), .fault_src(fault_src)
  );

  // returns IRQ number, -1 for dropped, -2 for illegal target
  function automatic int route(int src, int line);
    int r;
    int lim;
    if (src >= 12) return -1;
    case (src)
      8:       r = rt_byte_a >> 4;
      9:       r = rt_byte_bc & 15;
      10:      r = rt_byte_bc >> 4;
      11:      r = rt_byte_d >> 4;
      default: r = line;
    endcase
    if (r == 0 || r == 255) return -1;
    lim = (src == 2 || src == 3 || src == 5) ? 14 : 15;
    if (r == 2 || r > lim) return -2;
    return r;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (isa_irq !== exp_irq) begin
      fails++;
      $display("FAIL %s isa_irq actual=%h expected=%h", tag, isa_irq, exp_irq);
    end else if (fault_valid !== exp_fault) begin
      fails++;
      $display("FAIL %s fault_valid actual=%b expected=%b", tag, fault_valid, exp_fault);
    end else if (exp_fault && fault_src !== 4'(exp_fsrc)) begin
      fails++;
      $display("FAIL %s fault_src actual=%0d expected=%0d", tag, fault_src, exp_fsrc);
    end
  endtask

  // present one event (or an idle cycle), advance one clock, compare
  task automatic tick(bit v, bit lv, int src, int line, string tag);
    int r;
    evt_valid = v;
    evt_level = lv;
    evt_src   = 4'(src);
    evt_line  = 8'(line);
    exp_fault = 0;
    if (v) begin
      if (src < 12) live[src] = lv;
      r = route(src, line);
      if (r == -2) begin
        exp_fault = 1;
        exp_fsrc  = src;
      end else if (r >= 0) begin
        bmap[r][src] = lv;
        bmap[r] = bmap[r] & live;
      end
    end
    @(negedge clk);
    evt_valid = 0;
    for (int k = 0; k < 16; k++) exp_irq[k] = |bmap[k];
    compare(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    live = '0;
    for (int k = 0; k < 16; k++) bmap[k] = '0;
    exp_irq = '0;
    exp_fault = 0;
    exp_fsrc = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    compare("R1 reset state");

    // R3 / R8: internal function with own line number
    tick(1, 1, 4, 5, "R3 src4 to irq5 asserted");
    tick(0, 0, 0, 0, "R8 idle holds");
    tick(1, 0, 4, 5, "R3 src4 released");

    // R7: shared IRQ stays high until the last source drops
    tick(1, 1, 0, 7, "R7 src0 on irq7");
    tick(1, 1, 1, 7, "R7 src1 on irq7");
    tick(1, 0, 0, 7, "R7 src0 off irq7 still high");
    tick(1, 0, 1, 7, "R7 src1 off irq7 low");

    // R2: PCI pins from config nibbles, evt_line ignored
    rt_byte_a = 8'h96; rt_byte_bc = 8'hA3; rt_byte_d = 8'hB4;
    tick(1, 1, 8, 4, "R2 pin A upper nibble 9");
    tick(1, 1, 9, 12, "R2 pin B lower nibble 3");
    tick(1, 1, 10, 0, "R2 pin C upper nibble 10");
    tick(1, 1, 11, 4, "R2 pin D upper nibble 11");
    tick(1, 0, 8, 0, "R2 pin A off");
    tick(1, 0, 9, 0, "R2 pin B off");
    tick(1, 0, 10, 0, "R2 pin C off");
    tick(1, 0, 11, 0, "R2 pin D off");

    // R4: disabled routes
    tick(1, 1, 6, 0, "R4 line 0 disabled");
    tick(1, 1, 6, 255, "R4 line 0xFF disabled");
    rt_byte_a = 8'h0F;
    tick(1, 1, 8, 3, "R4 pin nibble 0 disabled");
    tick(1, 0, 8, 3, "R4 pin nibble 0 release");
    tick(1, 0, 6, 0, "R4 src6 release disabled");

    // R6: stale bit masked by live vector after re-route
    tick(1, 1, 4, 5, "R6 src4 on irq5");
    tick(1, 0, 4, 0, "R6 src4 drops while disabled irq5 held");
    tick(1, 1, 6, 5, "R6 src6 joins irq5");
    tick(1, 0, 6, 5, "R6 src6 leaves irq5 stale bit gone");

    // R5 / R10: illegal targets and per-source limits
    tick(1, 1, 1, 2, "R5 internal to irq2");
    tick(1, 1, 2, 15, "R5 src2 above limit 14");
    tick(0, 0, 0, 0, "R10 fault pulse ends");
    tick(1, 1, 2, 14, "R5 src2 at limit 14");
    tick(1, 1, 7, 15, "R5 src7 at limit 15");
    tick(1, 1, 5, 15, "R5 src5 above limit 14");
    tick(1, 1, 0, 16, "R5 src0 above limit 15");
    rt_byte_a = 8'h20;
    tick(1, 1, 8, 9, "R5 pin A nibble 2");
    rt_byte_a = 8'hF0;
    tick(1, 1, 8, 9, "R5 pin A nibble 15 legal");
    tick(1, 0, 8, 9, "R5 pin A release");
    tick(1, 0, 2, 14, "R5 src2 release");
    tick(1, 0, 7, 15, "R5 src7 release");

    // R9: unknown source IDs
    tick(1, 1, 13, 5, "R9 src13 ignored");
    tick(1, 1, 12, 2, "R9 src12 no fault");
    tick(0, 0, 0, 0, "R10 idle after ignored");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule